// File: doc/BRIEF.md
# Two-Input Four-Phase Lamp Sequencer

This block is a Moore state machine with four phases held in a 2-bit code. On each rising clock edge it moves between phases according to two level inputs, an advance request and a continue qualifier. It drives one lamp per phase. After the first clock edge following reset, exactly one lamp is lit: the lamp for the current phase.

The phase walk is deliberately asymmetric. Phases are named here by their code. From REST (00), the advance input alone decides whether to move to ARM (10). ARM splits on the continue input. It goes to LATCH (11) when continue is high and to HOLD (01) when it is low. In HOLD and LATCH, a low continue input always wins and returns the machine to REST. With continue high, the advance input picks LATCH when high and HOLD when low.

The lamps are registered alongside the phase, so a lamp changes on the same edge as the phase. An asynchronous active-low reset clears the lamps and forces REST. A host uses the block by holding the two inputs stable around each rising edge and watching the lamp vector.

Top module: `lamp_fsm_ctrl`

## Requirements
- R1: While rst_n is low, and after its release until the first rising clock edge, lamp_o is 4'b0000 and the phase is REST (code 00).
- R2: In REST, advance_i=1 moves to ARM (code 10) and advance_i=0 stays in REST. The value of continue_i has no effect in REST.
- R3: In ARM, continue_i=0 moves to HOLD (code 01) and continue_i=1 moves to LATCH (code 11). advance_i has no effect in ARM.
- R4: In HOLD, continue_i=0 returns to REST whatever advance_i is (highest priority). Otherwise advance_i=1 moves to LATCH and advance_i=0 stays in HOLD.
- R5: In LATCH, continue_i=0 returns to REST whatever advance_i is. Otherwise advance_i=0 moves to HOLD and advance_i=1 stays in LATCH.
- R6: From the first rising edge after reset, lamp_o is one-hot, and bit k is set exactly when the phase code equals k (bit0 REST, bit1 HOLD, bit2 ARM, bit3 LATCH). The lamp is updated on the same edge as the phase.
- R7: Driving rst_n low at any time clears lamp_o at once, without waiting for a clock edge, and the next phase after release is computed from REST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance_i | input | 1 | Advance request |
| continue_i | input | 1 | Continue qualifier; low returns the machine to REST from HOLD or LATCH |
| lamp_o | output | 4 | One lamp per phase, bit index equal to the phase code |

## Verification
The assertions take for granted that advance_i and continue_i are settled before each rising edge. They also assume that reset is the only way the lamps can be all dark. The bench changes both inputs only on the falling edge, so they are stable through every sampling edge. It asserts reset between edges only, in its directed asynchronous-reset case. The random stimulus runs long enough to visit every phase with all four input combinations.

// File: rtl/lamp_fsm_pkg.sv
package lamp_fsm_pkg;

    localparam int NUM_PHASES = 4;
    localparam int PHASE_W    = $clog2(NUM_PHASES);

    typedef enum logic [PHASE_W-1:0] {
        PH_REST  = 2'd0,
        PH_HOLD  = 2'd1,
        PH_ARM   = 2'd2,
        PH_LATCH = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e                  phase;
        logic [NUM_PHASES-1:0]   lamp;
    } ctrl_s;

endpackage

// File: rtl/lamp_fsm_next.sv
module lamp_fsm_next
    import lamp_fsm_pkg::*;
(
    input  phase_e cur_phase,
    input  logic   advance,
    input  logic   cont,
    output phase_e nxt_phase,
    output logic   code_known
);

    always_comb begin
        nxt_phase  = PH_REST;
        code_known = 1'b1;
        case (cur_phase)
            PH_REST: begin
                // only the advance request matters here
                nxt_phase = advance ? PH_ARM : PH_REST;
            end
            PH_ARM: begin
                nxt_phase = cont ? PH_LATCH : PH_HOLD;
            end
            PH_HOLD: begin
                // a low qualifier outranks the advance request
                if (!cont)        nxt_phase = PH_REST;
                else if (advance) nxt_phase = PH_LATCH;
                else              nxt_phase = PH_HOLD;
            end
            PH_LATCH: begin
                if (!cont)        nxt_phase = PH_REST;
                else if (!advance) nxt_phase = PH_HOLD;
                else              nxt_phase = PH_LATCH;
            end
            default: begin
                nxt_phase  = PH_REST;
                code_known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lamp_fsm_decode.sv
module lamp_fsm_decode
    import lamp_fsm_pkg::*;
#(
    parameter int N_LAMPS = NUM_PHASES
) (
    input  phase_e             phase,
    input  logic               enable,
    output logic [N_LAMPS-1:0] lamp
);

    localparam int SEL_W = (N_LAMPS > 1) ? $clog2(N_LAMPS) : 1;

    logic [SEL_W-1:0] sel;
    assign sel = SEL_W'(phase);

    for (genvar k = 0; k < N_LAMPS; k++) begin : g_lamp
        assign lamp[k] = enable && (sel == SEL_W'(k));
    end

endmodule

// File: rtl/lamp_fsm_ctrl.sv
module lamp_fsm_ctrl
    import lamp_fsm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  advance_i,
    input  logic                  continue_i,
    output logic [NUM_PHASES-1:0] lamp_o
);

    ctrl_s ctrl_d, ctrl_q;

    phase_e                nxt_phase;
    logic                  code_known;
    logic [NUM_PHASES-1:0] lamp_next;

    lamp_fsm_next u_next (
        .cur_phase  (ctrl_q.phase),
        .advance    (advance_i),
        .cont       (continue_i),
        .nxt_phase  (nxt_phase),
        .code_known (code_known)
    );

    lamp_fsm_decode #(.N_LAMPS(NUM_PHASES)) u_decode (
        .phase  (nxt_phase),
        .enable (code_known),
        .lamp   (lamp_next)
    );

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.phase = nxt_phase;
        // every lamp is rewritten each cycle, none keeps an old value
        ctrl_d.lamp  = lamp_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{phase: PH_REST, lamp: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign lamp_o = ctrl_q.lamp;

    AST_LAMP_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lamp_o)) else $error("lamp vector not one-hot");   // R6

    AST_LAMP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_o != '0) |-> lamp_o[ctrl_q.phase]) else $error("lamp mismatch");   // R6

    AST_REST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase == PH_REST && !advance_i) |=> (ctrl_q.phase == PH_REST)) else $error("rest exit");   // R2

    AST_REST_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase == PH_REST && advance_i) |=> (ctrl_q.phase == PH_ARM)) else $error("rest go");   // R2

    AST_ARM_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase == PH_ARM) |=> (ctrl_q.phase == (($past(continue_i)) ? PH_LATCH : PH_HOLD))) else $error("arm split");   // R3

    AST_HOLD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase == PH_HOLD && !continue_i) |=> (ctrl_q.phase == PH_REST)) else $error("hold abort");   // R4

    AST_LATCH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase == PH_LATCH && !continue_i) |=> (ctrl_q.phase == PH_REST)) else $error("latch abort");   // R5

    AST_LAMP_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (lamp_o != '0)) else $error("lamp dark after edge");   // R6

endmodule

// File: tb/lamp_fsm_ctrl_bench.sv
`timescale 1ns/1ps
module lamp_fsm_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       advance_i = 1'b0;
    logic       continue_i = 1'b0;
    logic [3:0] lamp_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int exp_ph   = 0;
    bit exp_lit  = 0;

    always #2.5 clk = ~clk;

    lamp_fsm_ctrl u_lamp_fsm_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance_i  (advance_i),
        .continue_i (continue_i),
        .lamp_o     (lamp_o)
    );

    function automatic int ref_next(int ph, bit adv, bit cont);
        case (ph)
            0: return adv ? 2 : 0;
            2: return cont ? 3 : 1;
            1: return !cont ? 0 : (adv ? 3 : 1);
            default: return !cont ? 0 : (adv ? 3 : 1);
        endcase
    endfunction

    function automatic string tag_of(int ph);
        case (ph)
            0: return "R2";
            1: return "R4";
            2: return "R3";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [3:0] ref_lamp();
        return exp_lit ? (4'b0001 << exp_ph) : 4'b0000;
    endfunction

    task automatic check(string req, logic [3:0] got, logic [3:0] want);
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: lamp_o=%b expected %b", req, got, want);
        end
    endtask

    // drive at the falling edge, let one rising edge pass, check at the next falling edge
    task automatic step(bit adv, bit cont);
        string req;
        advance_i  = adv;
        continue_i = cont;
        req = tag_of(exp_ph);
        @(posedge clk);
        exp_ph  = ref_next(exp_ph, adv, cont);
        exp_lit = 1;
        @(negedge clk);
        check(req, lamp_o, ref_lamp());
        n_checks++;
        if ($countones(lamp_o) != 1) begin
            n_fail++;
            $display("FAIL R6: lamp_o=%b expected one-hot", lamp_o);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", lamp_o, 4'b0000);
        rst_n = 1'b1;
        #1;
        check("R1", lamp_o, 4'b0000);
        @(negedge clk);
        exp_ph = 0; exp_lit = 0;

        // directed walk through every branch
        step(0, 1);   // R2 continue ignored, stay REST
        step(1, 0);   // R2 -> ARM
        step(0, 0);   // R3 -> HOLD
        step(1, 0);   // R4 priority, -> REST
        step(1, 1);   // R2 -> ARM
        step(1, 1);   // R3 -> LATCH
        step(1, 1);   // R5 stay
        step(0, 1);   // R5 -> HOLD
        step(0, 1);   // R4 stay
        step(1, 1);   // R4 -> LATCH
        step(1, 0);   // R5 -> REST
        step(1, 1);   // -> ARM
        step(0, 1);   // R3 advance ignored -> LATCH
        step(0, 0);   // R5 -> REST

        // R7: asynchronous reset away from the clock edge
        step(1, 0);
        #0.7 rst_n = 1'b0;
        #0.5 check("R7", lamp_o, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        exp_ph = 0; exp_lit = 0;
        step(1, 1);   // R7 next phase from REST -> ARM

        for (int i = 0; i < 600; i++) begin
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule